// File: doc/BRIEF.md
# Coprocessor Control Register Bank with Access Helpers

This block is the register file that a host processor uses to steer a bytecode coprocessor. It keeps the program counter, the stack pointer, the code offset, the local-variable pointer and the local count. It also keeps the time-slice counter, the slice reload value, a method-cache control word and a set of feature enables. The host reaches all of them over a simple request/acknowledge register bus with an 8-bit address.

Next to the plain registers the bank decodes helper addresses. A helper access turns a host sequence of read, compute and write back into a single bus transfer. A helper computes a local-memory address from the pointer registers and performs the memory access through its own local-memory port. It updates the pointer that was used as a side effect and, for some addresses, issues a one-cycle execute pulse that resumes the coprocessor. Stack words can be moved to and from the top of stack. Instruction parameters can be fetched with the program counter advancing. The method id and the constant-pool address held just below the current code segment can be read. A new method can be entered with two writes.

The slice counter counts down while the coprocessor runs. It signals the end of each slice and then reloads from a reload register that software sets once and that keeps its value.

Top module: `cpx_ctrl_bank`

## Requirements
- R1: After synchronous reset every register reads as zero, and exec_start, slice_expired, hst_ack and mem_req are low.
- R2: Plain registers sit at addresses 0 (PC), 1 (ST), 2 (CO), 3 (LV), 4 (LO), 16 (slice counter), 17 (slice reload), 128 (method-cache control) and 129 (feature enables). A write stores the low bits that fit the register. A read returns the value zero-extended. Both complete with hst_ack one cycle after the request is taken.
- R3: A read at 64 returns the local-memory word at ST and then decrements ST. Every memory helper acknowledges three cycles after the request is taken, and mem_req is a single-cycle pulse.
- R4: A write at 64 stores the data at ST+1 and leaves ST at ST+1, without an execute pulse. ST changes only in a cycle where hst_ack is high.
- R5: A write at 65 acts like a write at 64 and also raises exec_start for exactly one cycle, in the acknowledge cycle, after the memory write. A read at 65 returns zero and changes nothing.
- R6: A read at 66 returns the local-memory word at CO+PC and then increments PC.
- R7: Reads at 70 and 71 return the local-memory words at CO-2 and CO-1 and change no register.
- R8: A write at 68 only stages a new code offset, so CO does not change. A write at 69 copies the staged offset into CO, stores the data into LO and raises exec_start for one cycle. Both addresses read as zero.
- R9: While cop_running is high, the slice counter decrements once per cycle. In a cycle where it holds 1 or 0, it instead raises slice_expired for one cycle and loads the reload value, so a reload value N ≥ 1 gives slices of N cycles. The reload register keeps its value.
- R10: A host write to the slice counter takes priority over counting in the same cycle.
- R11: feat_en and mcache_ctrl follow the registers at 129 and 128 from the acknowledge cycle of the write.
- R12: Unmapped addresses, writes to read-only helpers and reads of write-only helpers read as zero and change no register.
- R13: Pointer arithmetic wraps modulo 2^MEM_AW. A push at ST = 2^MEM_AW−1 stores at 0, and a read at 70 with CO = 1 fetches from the last memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request, held until hst_ack |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 8 | Host register address |
| hst_wdata | input | DATA_W | Host write data |
| hst_ack | output | 1 | One-cycle completion pulse |
| hst_rdata | output | DATA_W | Read data, valid with hst_ack |
| mem_req | output | 1 | Local-memory access strobe |
| mem_we | output | 1 | Local-memory write enable |
| mem_addr | output | MEM_AW | Local-memory word address |
| mem_wdata | output | DATA_W | Local-memory write data |
| mem_rdata | input | DATA_W | Local-memory read data, one cycle after the strobe |
| cop_running | input | 1 | Coprocessor is executing |
| exec_start | output | 1 | One-cycle resume pulse |
| slice_expired | output | 1 | One-cycle end-of-slice pulse |
| ctl_pc | output | MEM_AW | Program counter |
| ctl_st | output | MEM_AW | Stack pointer |
| ctl_co | output | MEM_AW | Code offset |
| ctl_lv | output | MEM_AW | Local-variable pointer |
| ctl_lo | output | DATA_W | Local count |
| mcache_ctrl | output | MC_W | Method-cache control word |
| feat_en | output | FEAT_W | Feature enable bits |

## Verification
The bench builds the bank with MEM_AW = 6, SLICE_W = 8, FEAT_W = 4 and MC_W = 4. The 64-word local memory makes the pointer wrap within reach: a push from ST = 63 lands at word 0, and a method-id read with CO = 1 lands at word 63. The narrow pointers also show that wide host writes are truncated. The 8-bit slice counter keeps the slice-length and override tests short, while cycle-exact counts of slice lengths and of helper latency are still checked.

// File: rtl/cpx_ctrl_pkg.sv
package cpx_ctrl_pkg;

  localparam int unsigned BUS_AW = 8;

  // Host-visible address map
  localparam logic [BUS_AW-1:0] A_PC   = 8'd0;
  localparam logic [BUS_AW-1:0] A_ST   = 8'd1;
  localparam logic [BUS_AW-1:0] A_CO   = 8'd2;
  localparam logic [BUS_AW-1:0] A_LV   = 8'd3;
  localparam logic [BUS_AW-1:0] A_LO   = 8'd4;
  localparam logic [BUS_AW-1:0] A_SLC  = 8'd16;
  localparam logic [BUS_AW-1:0] A_SLR  = 8'd17;
  localparam logic [BUS_AW-1:0] A_STK  = 8'd64;
  localparam logic [BUS_AW-1:0] A_STKX = 8'd65;
  localparam logic [BUS_AW-1:0] A_PARM = 8'd66;
  localparam logic [BUS_AW-1:0] A_NCO  = 8'd68;
  localparam logic [BUS_AW-1:0] A_NLO  = 8'd69;
  localparam logic [BUS_AW-1:0] A_MID  = 8'd70;
  localparam logic [BUS_AW-1:0] A_CPL  = 8'd71;
  localparam logic [BUS_AW-1:0] A_MCC  = 8'd128;
  localparam logic [BUS_AW-1:0] A_FEAT = 8'd129;

  typedef enum logic [4:0] {
    OP_PC, OP_ST, OP_CO, OP_LV, OP_LO,
    OP_SLC, OP_SLR, OP_MCC, OP_FEAT,
    OP_STK, OP_STKX, OP_PARM,
    OP_NCO, OP_NLO, OP_MID, OP_CPL,
    OP_NONE
  } cpx_op_e;

  typedef enum logic [1:0] {
    K_NONE,    // acknowledged, no effect, reads zero
    K_REG,     // plain register access, one cycle
    K_MEM_RD,  // helper that reads local memory
    K_MEM_WR   // helper that writes local memory
  } cpx_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_DONE
  } cpx_state_e;

endpackage

// File: rtl/cpx_addr_decode.sv
module cpx_addr_decode
  import cpx_ctrl_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  input  logic              we,
  output cpx_op_e           op,
  output cpx_kind_e         kind
);

  always_comb begin
    unique case (addr)
      A_PC:    op = OP_PC;
      A_ST:    op = OP_ST;
      A_CO:    op = OP_CO;
      A_LV:    op = OP_LV;
      A_LO:    op = OP_LO;
      A_SLC:   op = OP_SLC;
      A_SLR:   op = OP_SLR;
      A_MCC:   op = OP_MCC;
      A_FEAT:  op = OP_FEAT;
      A_STK:   op = OP_STK;
      A_STKX:  op = OP_STKX;
      A_PARM:  op = OP_PARM;
      A_NCO:   op = OP_NCO;
      A_NLO:   op = OP_NLO;
      A_MID:   op = OP_MID;
      A_CPL:   op = OP_CPL;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_PC, OP_ST, OP_CO, OP_LV, OP_LO,
      OP_SLC, OP_SLR, OP_MCC, OP_FEAT: kind = K_REG;
      OP_STK:                          kind = we ? K_MEM_WR : K_MEM_RD;
      OP_STKX:                         kind = we ? K_MEM_WR : K_NONE;
      OP_PARM, OP_MID, OP_CPL:         kind = we ? K_NONE : K_MEM_RD;
      OP_NCO, OP_NLO:                  kind = we ? K_REG : K_NONE;
      default:                         kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/cpx_helper_agu.sv
module cpx_helper_agu
  import cpx_ctrl_pkg::*;
#(
  parameter int unsigned MEM_AW = 12
) (
  input  cpx_op_e           op,
  input  logic              we,
  input  logic [MEM_AW-1:0] st,
  input  logic [MEM_AW-1:0] pc,
  input  logic [MEM_AW-1:0] co,
  output logic [MEM_AW-1:0] addr
);

  localparam logic [MEM_AW-1:0] ONE = MEM_AW'(1);
  localparam logic [MEM_AW-1:0] TWO = MEM_AW'(2);

  // Addresses wrap naturally at the pointer width.
  always_comb begin
    unique case (op)
      OP_STK:  addr = we ? st + ONE : st;
      OP_STKX: addr = st + ONE;
      OP_PARM: addr = co + pc;
      OP_MID:  addr = co - TWO;
      OP_CPL:  addr = co - ONE;
      default: addr = st;
    endcase
  end

endmodule

// File: rtl/cpx_slice_timer.sv
module cpx_slice_timer #(
  parameter int unsigned SLICE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               ld_cnt,
  input  logic               ld_rld,
  input  logic [SLICE_W-1:0] wdata,
  output logic [SLICE_W-1:0] cnt,
  output logic [SLICE_W-1:0] rld,
  output logic               expired
);

  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  logic last_tick;
  assign last_tick = (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rld     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (ld_rld) rld <= wdata;
      if (ld_cnt) begin
        cnt <= wdata;              // host write wins over counting
      end else if (run) begin
        if (last_tick) begin
          cnt     <= rld;          // reload value itself is kept
          expired <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/cpx_ctrl_bank.sv
module cpx_ctrl_bank
  import cpx_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MEM_AW  = 12,
  parameter int unsigned SLICE_W = 16,
  parameter int unsigned FEAT_W  = 8,
  parameter int unsigned MC_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_req,
  input  logic               hst_we,
  input  logic [7:0]         hst_addr,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic               hst_ack,
  output logic [DATA_W-1:0]  hst_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               cop_running,
  output logic               exec_start,
  output logic               slice_expired,
  output logic [MEM_AW-1:0]  ctl_pc,
  output logic [MEM_AW-1:0]  ctl_st,
  output logic [MEM_AW-1:0]  ctl_co,
  output logic [MEM_AW-1:0]  ctl_lv,
  output logic [DATA_W-1:0]  ctl_lo,
  output logic [MC_W-1:0]    mcache_ctrl,
  output logic [FEAT_W-1:0]  feat_en
);

  localparam logic [MEM_AW-1:0] P_ONE = MEM_AW'(1);

  cpx_op_e           dec_op;
  cpx_kind_e         dec_kind;
  logic [MEM_AW-1:0] agu_addr;
  cpx_state_e        state;
  cpx_op_e           pend_op;
  logic              pend_wr;
  logic [MEM_AW-1:0] new_co;
  logic [SLICE_W-1:0] slc_cnt, slc_rld;
  logic              take, reg_wr;
  logic [DATA_W-1:0] reg_rdata;

  cpx_addr_decode i_dec (
    .addr (hst_addr),
    .we   (hst_we),
    .op   (dec_op),
    .kind (dec_kind)
  );

  cpx_helper_agu #(.MEM_AW(MEM_AW)) i_agu (
    .op   (dec_op),
    .we   (hst_we),
    .st   (ctl_st),
    .pc   (ctl_pc),
    .co   (ctl_co),
    .addr (agu_addr)
  );

  assign take   = (state == S_IDLE) && hst_req;
  assign reg_wr = take && hst_we && (dec_kind == K_REG);

  cpx_slice_timer #(.SLICE_W(SLICE_W)) i_slice (
    .clk     (clk),
    .rst     (rst),
    .run     (cop_running),
    .ld_cnt  (reg_wr && (dec_op == OP_SLC)),
    .ld_rld  (reg_wr && (dec_op == OP_SLR)),
    .wdata   (hst_wdata[SLICE_W-1:0]),
    .cnt     (slc_cnt),
    .rld     (slc_rld),
    .expired (slice_expired)
  );

  // Read mux for plain registers; everything else reads zero.
  always_comb begin
    reg_rdata = '0;
    if (dec_kind == K_REG) begin
      unique case (dec_op)
        OP_PC:   reg_rdata = DATA_W'(ctl_pc);
        OP_ST:   reg_rdata = DATA_W'(ctl_st);
        OP_CO:   reg_rdata = DATA_W'(ctl_co);
        OP_LV:   reg_rdata = DATA_W'(ctl_lv);
        OP_LO:   reg_rdata = ctl_lo;
        OP_SLC:  reg_rdata = DATA_W'(slc_cnt);
        OP_SLR:  reg_rdata = DATA_W'(slc_rld);
        OP_MCC:  reg_rdata = DATA_W'(mcache_ctrl);
        OP_FEAT: reg_rdata = DATA_W'(feat_en);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      pend_op     <= OP_NONE;
      pend_wr     <= 1'b0;
      hst_ack     <= 1'b0;
      hst_rdata   <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      exec_start  <= 1'b0;
      ctl_pc      <= '0;
      ctl_st      <= '0;
      ctl_co      <= '0;
      ctl_lv      <= '0;
      ctl_lo      <= '0;
      new_co      <= '0;
      mcache_ctrl <= '0;
      feat_en     <= '0;
    end else begin
      hst_ack    <= 1'b0;
      mem_req    <= 1'b0;
      exec_start <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (take) begin
            if (dec_kind == K_MEM_RD || dec_kind == K_MEM_WR) begin
              mem_req   <= 1'b1;
              mem_we    <= (dec_kind == K_MEM_WR);
              mem_addr  <= agu_addr;
              mem_wdata <= hst_wdata;
              pend_op   <= dec_op;
              pend_wr   <= (dec_kind == K_MEM_WR);
              state     <= S_WAIT;
            end else begin
              hst_ack <= 1'b1;
              if (!hst_we) hst_rdata <= reg_rdata;
              if (reg_wr) begin
                unique case (dec_op)
                  OP_PC:   ctl_pc      <= hst_wdata[MEM_AW-1:0];
                  OP_ST:   ctl_st      <= hst_wdata[MEM_AW-1:0];
                  OP_CO:   ctl_co      <= hst_wdata[MEM_AW-1:0];
                  OP_LV:   ctl_lv      <= hst_wdata[MEM_AW-1:0];
                  OP_LO:   ctl_lo      <= hst_wdata;
                  OP_MCC:  mcache_ctrl <= hst_wdata[MC_W-1:0];
                  OP_FEAT: feat_en     <= hst_wdata[FEAT_W-1:0];
                  OP_NCO:  new_co      <= hst_wdata[MEM_AW-1:0];
                  OP_NLO: begin
                    ctl_co     <= new_co;
                    ctl_lo     <= hst_wdata;
                    exec_start <= 1'b1;
                  end
                  default: ;
                endcase
              end
            end
          end
        end
        S_WAIT: state <= S_DONE;   // memory acts on this edge
        S_DONE: begin
          state   <= S_IDLE;
          hst_ack <= 1'b1;
          if (!pend_wr) hst_rdata <= mem_rdata;
          unique case (pend_op)
            OP_STK:  ctl_st <= pend_wr ? ctl_st + P_ONE : ctl_st - P_ONE;
            OP_STKX: begin
              ctl_st     <= ctl_st + P_ONE;
              exec_start <= 1'b1;  // memory write already done
            end
            OP_PARM: ctl_pc <= ctl_pc + P_ONE;
            default: ;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cpx_ctrl_bank_chk.sv
module cpx_ctrl_bank_chk #(
  parameter int unsigned MEM_AW = 12,
  parameter int unsigned FEAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_ack,
  input logic              exec_start,
  input logic              mem_req,
  input logic              slice_expired,
  input logic              cop_running,
  input logic [FEAT_W-1:0] feat_en,
  input logic [MEM_AW-1:0] ctl_st,
  input logic [MEM_AW-1:0] ctl_pc
);

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    hst_ack |=> !hst_ack);

  assert_mem_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  assert_st_only_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl_st) |-> hst_ack);

  assert_exec_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> hst_ack);

  assert_pc_only_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl_pc) |-> hst_ack);

  assert_expire_running_R9: assert property (@(posedge clk) disable iff (rst)
    slice_expired |-> $past(cop_running));

  assert_expire_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (slice_expired && !cop_running) |=> !slice_expired);

  assert_feat_on_ack_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(feat_en) |-> hst_ack);

endmodule

bind cpx_ctrl_bank cpx_ctrl_bank_chk #(.MEM_AW(MEM_AW), .FEAT_W(FEAT_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .hst_ack       (hst_ack),
  .exec_start    (exec_start),
  .mem_req       (mem_req),
  .slice_expired (slice_expired),
  .cop_running   (cop_running),
  .feat_en       (feat_en),
  .ctl_st        (ctl_st),
  .ctl_pc        (ctl_pc)
);

// File: tb/test_cpx_ctrl_bank.sv
`timescale 1ns/1ps
module test_cpx_ctrl_bank;

  localparam int DW = 32, AW = 6, SW = 8, FW = 4, MW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hst_req = 1'b0, hst_we = 1'b0;
  logic [7:0]    hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0;
  logic          hst_ack;
  logic [DW-1:0] hst_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          cop_running = 1'b0;
  logic          exec_start, slice_expired;
  logic [AW-1:0] ctl_pc, ctl_st, ctl_co, ctl_lv;
  logic [DW-1:0] ctl_lo;
  logic [MW-1:0] mcache_ctrl;
  logic [FW-1:0] feat_en;

  always #10 clk = ~clk;  // 50 MHz

  cpx_ctrl_bank #(.DATA_W(DW), .MEM_AW(AW), .SLICE_W(SW), .FEAT_W(FW), .MC_W(MW))
  i_cpx_ctrl_bank (
    .clk(clk), .rst(rst), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cop_running(cop_running), .exec_start(exec_start),
    .slice_expired(slice_expired), .ctl_pc(ctl_pc), .ctl_st(ctl_st), .ctl_co(ctl_co),
    .ctl_lv(ctl_lv), .ctl_lo(ctl_lo), .mcache_ctrl(mcache_ctrl), .feat_en(feat_en)
  );

  // Local-memory model: synchronous, one-cycle read, with a bench-side load port.
  logic [DW-1:0] mem [1<<AW];
  logic          bd_we = 1'b0;
  logic [AW-1:0] bd_a  = '0;
  logic [DW-1:0] bd_d  = '0;
  always @(posedge clk) begin
    if (bd_we) mem[bd_a] <= bd_d;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, errors = 0;
  int last_lat;
  logic last_exec;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [7:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
    last_lat = 0;
    do begin @(negedge clk); last_lat++; end while (!hst_ack && last_lat < 20);
    rd = hst_rdata;
    last_exec = exec_start;
    hst_req = 1'b0; hst_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] unused;
    bus(1'b1, a, d, unused);
  endtask

  task automatic rd(input logic [7:0] a, output logic [DW-1:0] q);
    bus(1'b0, a, '0, q);
  endtask

  task automatic bd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_a = a; bd_d = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] q;
    chk("R1 exec_start", DW'(exec_start), 0);
    chk("R1 slice_expired", DW'(slice_expired), 0);
    chk("R1 hst_ack", DW'(hst_ack), 0);
    chk("R1 mem_req", DW'(mem_req), 0);
    foreach (q[i]) if (i < 1) ; // keep q used
    rd(8'd0, q);   chk("R1 PC", q, 0);
    rd(8'd1, q);   chk("R1 ST", q, 0);
    rd(8'd2, q);   chk("R1 CO", q, 0);
    rd(8'd4, q);   chk("R1 LO", q, 0);
    rd(8'd16, q);  chk("R1 slice counter", q, 0);
    rd(8'd17, q);  chk("R1 slice reload", q, 0);
    rd(8'd129, q); chk("R1 feature reg", q, 0);
  endtask

  task automatic t_plain;
    logic [DW-1:0] q;
    wr(8'd0, 32'h0000_01FF); chk("R2 write latency", last_lat, 1);
    rd(8'd0, q); chk("R2 PC truncated readback", q, 32'h3F);
    chk("R2 read latency", last_lat, 1);
    wr(8'd3, 32'd17); rd(8'd3, q); chk("R2 LV readback", q, 17);
    wr(8'd4, 32'hDEAD_BEEF); rd(8'd4, q); chk("R2 LO readback", q, 32'hDEAD_BEEF);
    chk("R2 ctl_lo port", ctl_lo, 32'hDEAD_BEEF);
    wr(8'd0, 32'd0);
  endtask

  task automatic t_stack;
    logic [DW-1:0] q;
    wr(8'd1, 32'd10);
    wr(8'd64, 32'hAAAA_0001);
    chk("R4 push latency", last_lat, 3);
    chk("R4 no exec on plain push", DW'(last_exec), 0);
    chk("R4 ST after push", DW'(ctl_st), 11);
    chk("R4 memory at ST+1", mem[11], 32'hAAAA_0001);
    wr(8'd64, 32'hAAAA_0002);
    rd(8'd64, q); chk("R3 pop returns newest", q, 32'hAAAA_0002);
    chk("R3 pop latency", last_lat, 3);
    chk("R3 ST after pop", DW'(ctl_st), 11);
    rd(8'd64, q); chk("R3 pop returns older", q, 32'hAAAA_0001);
    chk("R3 ST after second pop", DW'(ctl_st), 10);
  endtask

  task automatic t_stack_exec;
    logic [DW-1:0] q;
    wr(8'd65, 32'hBEEF_0065);
    chk("R5 exec pulse with ack", DW'(last_exec), 1);
    chk("R5 memory written", mem[11], 32'hBEEF_0065);
    chk("R5 ST after exec push", DW'(ctl_st), 11);
    @(negedge clk); chk("R5 exec is one cycle", DW'(exec_start), 0);
    rd(8'd65, q); chk("R5 read of 65 is zero", q, 0);
    chk("R5 read of 65 no exec", DW'(last_exec), 0);
    chk("R5 read of 65 keeps ST", DW'(ctl_st), 11);
  endtask

  task automatic t_param;
    logic [DW-1:0] q;
    bd_write(6'd23, 32'h0000_0123);
    bd_write(6'd24, 32'h0000_0124);
    wr(8'd2, 32'd20); wr(8'd0, 32'd3);
    rd(8'd66, q); chk("R6 first parameter", q, 32'h123);
    chk("R6 PC advanced", DW'(ctl_pc), 4);
    rd(8'd66, q); chk("R6 second parameter", q, 32'h124);
    chk("R6 PC advanced again", DW'(ctl_pc), 5);
  endtask

  task automatic t_method_info;
    logic [DW-1:0] q;
    bd_write(6'd18, 32'h0000_0AD0);
    bd_write(6'd19, 32'h0000_0C90);
    rd(8'd70, q); chk("R7 method id at CO-2", q, 32'hAD0);
    rd(8'd71, q); chk("R7 constant pool at CO-1", q, 32'hC90);
    chk("R7 CO unchanged", DW'(ctl_co), 20);
    chk("R7 PC unchanged", DW'(ctl_pc), 5);
  endtask

  task automatic t_invoke;
    logic [DW-1:0] q;
    wr(8'd68, 32'd30);
    chk("R8 staging no exec", DW'(last_exec), 0);
    rd(8'd2, q); chk("R8 CO not yet changed", q, 20);
    rd(8'd68, q); chk("R8 read of 68 is zero", q, 0);
    wr(8'd69, 32'd7);
    chk("R8 exec on new LO", DW'(last_exec), 1);
    chk("R8 CO committed", DW'(ctl_co), 30);
    chk("R8 LO loaded", ctl_lo, 7);
  endtask

  task automatic t_slice;
    logic [DW-1:0] q;
    int n;
    wr(8'd17, 32'd5); wr(8'd16, 32'd3);
    @(negedge clk); cop_running = 1'b1;
    n = 0; do begin @(negedge clk); n++; end while (!slice_expired && n < 50);
    chk("R9 first slice length", n, 3);
    n = 0; do begin @(negedge clk); n++; end while (!slice_expired && n < 50);
    cop_running = 1'b0;
    chk("R9 reloaded slice length", n, 5);
    @(negedge clk); chk("R9 expire is one cycle", DW'(slice_expired), 0);
    rd(8'd17, q); chk("R9 reload kept", q, 5);
    rd(8'd16, q); chk("R9 counter holds when stopped", q, 5);
    cop_running = 1'b1;
    wr(8'd16, 32'd2);
    n = 0; do begin @(negedge clk); n++; end while (!slice_expired && n < 50);
    cop_running = 1'b0;
    chk("R10 host write overrides count", n, 2);
  endtask

  task automatic t_feat;
    logic [DW-1:0] q;
    wr(8'd129, 32'hFFFF_FFFA);
    chk("R11 feat_en follows write", DW'(feat_en), 32'hA);
    rd(8'd129, q); chk("R11 feature readback", q, 32'hA);
    wr(8'd128, 32'd6);
    chk("R11 mcache_ctrl follows write", DW'(mcache_ctrl), 6);
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] q;
    wr(8'd200, 32'h1234_5678);
    rd(8'd200, q); chk("R12 unmapped reads zero", q, 0);
    wr(8'd70, 32'd9); chk("R12 write to 70 keeps CO", DW'(ctl_co), 30);
    wr(8'd66, 32'd9); chk("R12 write to 66 keeps PC", DW'(ctl_pc), 5);
    chk("R12 unmapped keeps feat_en", DW'(feat_en), 32'hA);
  endtask

  task automatic t_wrap;
    logic [DW-1:0] q;
    wr(8'd1, 32'd63);
    wr(8'd64, 32'h0000_5A5A);
    chk("R13 ST wraps to 0", DW'(ctl_st), 0);
    chk("R13 push lands at word 0", mem[0], 32'h5A5A);
    rd(8'd64, q); chk("R13 pop from word 0", q, 32'h5A5A);
    chk("R13 ST wraps back to 63", DW'(ctl_st), 63);
    bd_write(6'd63, 32'h0000_3F3F);
    wr(8'd2, 32'd1);
    rd(8'd70, q); chk("R13 CO-2 wraps to last word", q, 32'h3F3F);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_plain();
    t_stack();
    t_stack_exec();
    t_param();
    t_method_info();
    t_invoke();
    t_slice();
    t_feat();
    t_unmapped();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule